// File: doc/BRIEF.md
# T1/E1 Transmit Line Encoder

This block turns the system-side transmit bit stream of one T1/E1 channel into the positive and negative rail pulses that feed the line driver. It runs on the transmit clock. The channel works in one of two ways. In dual-rail operation the two system rails go straight to the two line rails. In single-rail operation a single data input is encoded as alternate mark inversion. Zero substitution can be added on top of that: eight-zero substitution at the T1 rate, or four-zero high-density substitution at the E1 rate.

Single-rail operation can be selected in two ways. The first is automatic: the negative-rail input is held high for more than sixteen clocks in a row. The second is by setting both configuration bits. When both bits are set and plain alternate mark inversion is active, a command input can force a deliberate bipolar violation.

The stream carries one symbol per clock and has no back-pressure. The upstream framer must present a bit on every transmit clock, and the rails emit one symbol per clock. There is no valid or ready signal, because a line interface cannot pause. The encoder looks ahead across a zero run before it decides on a substitution, so its delay is fixed by the rate: 8 clocks at T1 and 4 clocks at E1. The same delay applies whether or not substitution is enabled, so changing the code does not move the timing.

Top module: `tle_tx_encoder`

## Requirements
- R1: In dual-rail operation, `line_pos_o`/`line_neg_o` take the values of `td_pos_i`/`td_neg_i` on the same clock edge that samples them.
- R2: When `td_neg_i` is sampled high on 17 consecutive edges, the edge after the 17th drives the rails from the encoder instead of the pass-through path.
- R3: One low sample of `td_neg_i` clears the high-run count. The next edge returns the rails to pass-through.
- R4: Single-rail operation by configuration needs `cfg_single_i` and `cfg_crs_i` both at 1. Either bit alone leaves the block in pass-through.
- R5: With `code_sub_i`=0 (alternate mark inversion), each 1 gives a pulse of the opposite polarity to the previous pulse, and each 0 gives no pulse. In single-rail operation both rails are never high together.
- R6: With `code_sub_i`=1 and `rate_t1_i`=1, each run of eight zeros is sent as 0,0,0,V,B,0,V,B. V repeats the polarity of the pulse before it and B reverses it. At most seven pulse-free slots occur in a row.
- R7: With `code_sub_i`=1 and `rate_t1_i`=0, each run of four zeros is sent as B,0,0,V when an even number of non-violation pulses has been sent since the last V (or since reset), and as 0,0,0,V when that number is odd. At most three pulse-free slots occur in a row.
- R8: A single-rail bit appears on the rails 8 edges after the edge that samples it when `rate_t1_i`=1, and 4 edges after when `rate_t1_i`=0. This holds for both codes.
- R9: With both configuration bits set and `code_sub_i`=0, a high `bpv_i` replaces the sampled bit with a pulse of the same polarity as the previous pulse.
- R10: `bpv_i` has no effect on the rails when `code_sub_i`=1.
- R11: While reset is asserted both rails are low. After reset the first mark is sent on the positive rail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| td_pos_i | input | 1 | Positive rail in dual-rail operation, data bit in single-rail operation |
| td_neg_i | input | 1 | Negative rail in dual-rail operation; held high to select single-rail operation |
| bpv_i | input | 1 | Forces a bipolar violation in the current slot |
| code_sub_i | input | 1 | 0 = alternate mark inversion, 1 = zero substitution for the selected rate |
| rate_t1_i | input | 1 | 1 = T1 rate (eight-zero substitution), 0 = E1 rate (four-zero substitution) |
| cfg_single_i | input | 1 | Configuration bit requesting single-rail operation |
| cfg_crs_i | input | 1 | Configuration bit that must also be set to select single-rail operation |
| line_pos_o | output | 1 | Positive line rail |
| line_neg_o | output | 1 | Negative line rail |

## Verification
The pulse-gap assertions assume that the code select and the rate select change only while reset is asserted. The bench therefore sets them during reset and holds them for the whole segment that follows. The pass-through stimulus forces `td_neg_i` low at least once every eight clocks, so that automatic single-rail entry only happens in the segment built to cause it. The bench holds `td_neg_i` low whenever single-rail operation is selected by configuration, and it starts each encoded segment on the first edge after reset. As a result, the expected polarity and parity always start from the reset state.

// File: rtl/tle_pkg.sv
package tle_pkg;
  localparam int B8ZS_RUN = 8;
  localparam int HDB3_RUN = 4;

  typedef enum logic [2:0] {
    SYM_IDLE  = 3'd0,
    SYM_SPACE = 3'd1,
    SYM_MARK  = 3'd2,
    SYM_VIOL  = 3'd3,
    SYM_BIP   = 3'd4,
    SYM_BCOND = 3'd5,
    SYM_FILL  = 3'd6
  } sym_e;
endpackage

// File: rtl/tle_rail_detect.sv
module tle_rail_detect #(
  parameter int SR_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tdn_i,
  output logic sr1_o
);
  localparam int CW = $clog2(SR_HOLD + 2);
  localparam logic [CW-1:0] LIMIT = CW'(SR_HOLD + 1);

  logic [CW-1:0] high_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                high_cnt_q <= '0;
    else if (!tdn_i)           high_cnt_q <= '0;
    else if (high_cnt_q != LIMIT) high_cnt_q <= high_cnt_q + 1'b1;
  end

  assign sr1_o = (high_cnt_q == LIMIT);

  AST_SR1_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr1_o) |-> $past(tdn_i)); // R2
  AST_SR1_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !tdn_i |=> !sr1_o); // R3
endmodule

// File: rtl/tle_sub_pipe.sv
module tle_sub_pipe
  import tle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic data_i,
  input  logic bpv_i,
  input  logic sub_en_i,
  input  logic rate_t1_i,
  output sym_e tap_o
);
  localparam int DEPTH = B8ZS_RUN;

  sym_e pipe_q [DEPTH];
  sym_e pipe_d [DEPTH];
  sym_e entry;
  logic run_t1, run_e1;

  always_comb begin
    entry = bpv_i ? SYM_VIOL : (data_i ? SYM_MARK : SYM_SPACE);
    // a run qualifies only if every slot is an untouched zero
    run_t1 = (entry == SYM_SPACE);
    for (int k = 0; k < B8ZS_RUN - 1; k++)
      if (pipe_q[k] != SYM_SPACE) run_t1 = 1'b0;
    run_e1 = (entry == SYM_SPACE);
    for (int k = 0; k < HDB3_RUN - 1; k++)
      if (pipe_q[k] != SYM_SPACE) run_e1 = 1'b0;

    pipe_d[0] = entry;
    for (int k = 1; k < DEPTH; k++) pipe_d[k] = pipe_q[k-1];

    // highest index is the oldest slot of the run
    if (sub_en_i && rate_t1_i && run_t1) begin
      pipe_d[7] = SYM_FILL;
      pipe_d[6] = SYM_FILL;
      pipe_d[5] = SYM_FILL;
      pipe_d[4] = SYM_VIOL;
      pipe_d[3] = SYM_BIP;
      pipe_d[2] = SYM_FILL;
      pipe_d[1] = SYM_VIOL;
      pipe_d[0] = SYM_BIP;
    end else if (sub_en_i && !rate_t1_i && run_e1) begin
      pipe_d[3] = SYM_BCOND;
      pipe_d[2] = SYM_FILL;
      pipe_d[1] = SYM_FILL;
      pipe_d[0] = SYM_VIOL;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= SYM_IDLE;
      else        pipe_q[g] <= pipe_d[g];
    end
  end

  assign tap_o = rate_t1_i ? pipe_q[B8ZS_RUN-1] : pipe_q[HDB3_RUN-1];
endmodule

// File: rtl/tle_polarity.sv
module tle_polarity
  import tle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sym_e sym_i,
  input  logic sub_en_i,
  input  logic rate_t1_i,
  output logic pulse_pos_o,
  output logic pulse_neg_o
);
  logic       last_pos_q;
  logic       odd_q;
  logic       fire;
  logic       pol;
  logic [3:0] gap_q;

  always_comb begin
    fire = 1'b0;
    pol  = !last_pos_q;
    case (sym_i)
      SYM_MARK, SYM_BIP: fire = 1'b1;
      SYM_VIOL: begin
        fire = 1'b1;
        pol  = last_pos_q;
      end
      SYM_BCOND: fire = !odd_q;
      default:   fire = 1'b0;
    endcase
  end

  assign pulse_pos_o = fire & pol;
  assign pulse_neg_o = fire & !pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      odd_q      <= 1'b0;
    end else begin
      if (fire) last_pos_q <= pol;
      case (sym_i)
        SYM_MARK, SYM_BIP: odd_q <= !odd_q;
        SYM_VIOL:          odd_q <= 1'b0;
        SYM_BCOND:         if (!odd_q) odd_q <= 1'b1;
        default:           odd_q <= odd_q;
      endcase
    end
  end

  // consecutive pulse-free symbols, used only by the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= '0;
    else if (fire || sym_i == SYM_IDLE) gap_q <= '0;
    else if (gap_q != 4'hF)        gap_q <= gap_q + 1'b1;
  end

  AST_B8ZS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en_i && rate_t1_i) |-> (gap_q < 4'(B8ZS_RUN))); // R6
  AST_HDB3_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en_i && !rate_t1_i) |-> (gap_q < 4'(HDB3_RUN))); // R7
endmodule

// File: rtl/tle_tx_encoder.sv
module tle_tx_encoder
  import tle_pkg::*;
#(
  parameter int SR_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic td_pos_i,
  input  logic td_neg_i,
  input  logic bpv_i,
  input  logic code_sub_i,
  input  logic rate_t1_i,
  input  logic cfg_single_i,
  input  logic cfg_crs_i,
  output logic line_pos_o,
  output logic line_neg_o
);
  logic sr1_w;
  logic cfg_mode_w;
  logic single_w;
  logic bpv_eff_w;
  logic enc_pos_w, enc_neg_w;
  sym_e tap_w;

  assign cfg_mode_w = cfg_single_i & cfg_crs_i;
  assign single_w   = sr1_w | cfg_mode_w;
  assign bpv_eff_w  = bpv_i & cfg_mode_w & !code_sub_i;

  tle_rail_detect #(.SR_HOLD(SR_HOLD)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .tdn_i (td_neg_i),
    .sr1_o (sr1_w)
  );

  tle_sub_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_i    (td_pos_i),
    .bpv_i     (bpv_eff_w),
    .sub_en_i  (code_sub_i),
    .rate_t1_i (rate_t1_i),
    .tap_o     (tap_w)
  );

  tle_polarity u_pol (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_i       (tap_w),
    .sub_en_i    (code_sub_i),
    .rate_t1_i   (rate_t1_i),
    .pulse_pos_o (enc_pos_w),
    .pulse_neg_o (enc_neg_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_pos_o <= 1'b0;
      line_neg_o <= 1'b0;
    end else if (single_w) begin
      line_pos_o <= enc_pos_w;
      line_neg_o <= enc_neg_w;
    end else begin
      line_pos_o <= td_pos_i;
      line_neg_o <= td_neg_i;
    end
  end

  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(single_w) |-> !(line_pos_o && line_neg_o)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!line_pos_o && !line_neg_o)); // R11
endmodule

// File: tb/tle_tx_encoder_tb.sv
`timescale 1ns/1ps
module tle_tx_encoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic td_pos = 1'b0, td_neg = 1'b0, bpv = 1'b0;
  logic code_sub = 1'b0, rate_t1 = 1'b1, cfg_single = 1'b0, cfg_crs = 1'b0;
  logic line_pos, line_neg;

  typedef struct {
    int    due;
    bit    p;
    bit    n;
    string req;
  } exp_t;

  exp_t sbq[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tle_tx_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .td_pos_i(td_pos), .td_neg_i(td_neg), .bpv_i(bpv),
    .code_sub_i(code_sub), .rate_t1_i(rate_t1), .cfg_single_i(cfg_single),
    .cfg_crs_i(cfg_crs), .line_pos_o(line_pos), .line_neg_o(line_neg)
  );

  task automatic check(string req, bit ap, bit an, bit ep, bit en);
    n_run++;
    if (ap !== ep || an !== en) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual pos/neg=%0b%0b expected=%0b%0b", req, cyc, ap, an, ep, en);
    end
  endtask

  task automatic push(int due, bit p, bit n, string req);
    exp_t e;
    e.due = due; e.p = p; e.n = n; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: compares the rails against the scoreboard when an item falls due
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      if (e.due != cyc) begin
        n_run++; n_fail++;
        $display("FAIL %s missed slot actual cyc=%0d expected cyc=%0d", e.req, cyc, e.due);
      end else check(e.req, line_pos, line_neg, e.p, e.n);
    end
  end

  task automatic do_reset(bit sub, bit t1, bit cs, bit cr);
    @(negedge clk);
    rst_n = 1'b0;
    td_pos = 1'b0; td_neg = 1'b0; bpv = 1'b0;
    code_sub = sub; rate_t1 = t1; cfg_single = cs; cfg_crs = cr;
    repeat (2) @(negedge clk);
    check("R11", line_pos, line_neg, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  task automatic addp(ref bit dq[$], ref bit bq[$], input bit v, input bit b, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      dq.push_back(v);
      bq.push_back(b);
    end
  endtask

  // reference: greedy zero-run replacement, then polarity assignment
  task automatic enc_segment(bit sub, bit t1, bit dq[$], bit bq[$], string req);
    int lat = t1 ? 8 : 4;
    bit d[$];
    bit b[$];
    int s[$];
    int i;
    bit lastpos = 1'b0;
    bit odd = 1'b0;
    d = dq; b = bq;
    for (int k = 0; k < lat; k++) begin d.push_back(1'b1); b.push_back(1'b0); end
    i = 0;
    while (i < d.size()) begin
      bit allz = sub && (i + lat <= d.size());
      for (int k = 0; k < lat; k++) if (allz && d[i+k]) allz = 1'b0;
      if (allz) begin
        if (t1) begin
          s.push_back(0); s.push_back(0); s.push_back(0); s.push_back(2);
          s.push_back(1); s.push_back(0); s.push_back(2); s.push_back(1);
        end else begin
          s.push_back(3); s.push_back(0); s.push_back(0); s.push_back(2);
        end
        i += lat;
      end else begin
        s.push_back((!sub && b[i]) ? 2 : (d[i] ? 1 : 0));
        i++;
      end
    end
    for (int k = 0; k < d.size(); k++) begin
      bit ep = 1'b0, en = 1'b0;
      case (s[k])
        1: begin ep = !lastpos; en = lastpos; lastpos = !lastpos; odd = !odd; end
        2: begin ep = lastpos; en = !lastpos; odd = 1'b0; end
        3: if (!odd) begin ep = !lastpos; en = lastpos; lastpos = !lastpos; odd = 1'b1; end
        default: ;
      endcase
      td_pos = d[k]; bpv = b[k]; td_neg = 1'b0;
      push(cyc + 1 + lat, ep, en, req);
      @(negedge clk);
    end
    drain();
  endtask

  task automatic dual_segment(int cycles, string req);
    for (int i = 0; i < cycles; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      td_pos = lf[0];
      td_neg = lf[1] & (i % 8 != 7);
      bpv = lf[2];
      push(cyc + 1, td_pos, td_neg, req);
      @(negedge clk);
    end
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit dq[$];
    bit bq[$];

    // R1: dual-rail pass-through, no configuration
    do_reset(1'b0, 1'b1, 1'b0, 1'b0);
    dual_segment(40, "R1");

    // R4: a single configuration bit keeps pass-through
    do_reset(1'b0, 1'b1, 1'b1, 1'b0);
    dual_segment(20, "R4");
    do_reset(1'b1, 1'b0, 1'b0, 1'b1);
    dual_segment(20, "R4");

    // R2 / R3: automatic single-rail entry from a held-high negative rail
    do_reset(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      td_neg = 1'b1; td_pos = 1'b0;
      push(cyc + 1, 1'b0, (i <= 16), "R2");
      @(negedge clk);
    end
    td_neg = 1'b0; td_pos = 1'b0;
    push(cyc + 1, 1'b0, 1'b0, "R3");
    @(negedge clk);
    td_neg = 1'b1; td_pos = 1'b1;
    push(cyc + 1, 1'b1, 1'b1, "R3");
    @(negedge clk);
    td_neg = 1'b1; td_pos = 1'b0;
    push(cyc + 1, 1'b0, 1'b1, "R3");
    @(negedge clk);
    drain();

    // R5 R9 R8 R11: AMI at T1 with forced violations
    dq.delete(); bq.delete();
    addp(dq, bq, 1, 0, 2); addp(dq, bq, 0, 0, 1); addp(dq, bq, 1, 0, 1);
    addp(dq, bq, 0, 1, 1); addp(dq, bq, 1, 0, 1); addp(dq, bq, 1, 1, 1);
    addp(dq, bq, 0, 0, 9); addp(dq, bq, 1, 0, 3);
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    enc_segment(1'b0, 1'b1, dq, bq, "R5 R9 R8");

    // R9 with a violation before any mark
    dq.delete(); bq.delete();
    addp(dq, bq, 0, 1, 1); addp(dq, bq, 1, 0, 3); addp(dq, bq, 0, 1, 1);
    do_reset(1'b0, 1'b0, 1'b1, 1'b1);
    enc_segment(1'b0, 1'b0, dq, bq, "R9 R11");

    // R6 R8: eight-zero substitution
    dq.delete(); bq.delete();
    addp(dq, bq, 1, 0, 1); addp(dq, bq, 0, 0, 8); addp(dq, bq, 1, 0, 2);
    addp(dq, bq, 0, 0, 16); addp(dq, bq, 1, 0, 1); addp(dq, bq, 0, 0, 7);
    addp(dq, bq, 1, 0, 1); addp(dq, bq, 0, 0, 12); addp(dq, bq, 1, 0, 1);
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    enc_segment(1'b1, 1'b1, dq, bq, "R6 R8");

    // R10: violation command ignored while substitution is selected
    dq.delete(); bq.delete();
    addp(dq, bq, 1, 1, 1); addp(dq, bq, 0, 1, 8); addp(dq, bq, 1, 1, 2);
    addp(dq, bq, 0, 1, 3); addp(dq, bq, 1, 0, 1);
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    enc_segment(1'b1, 1'b1, dq, bq, "R10");

    // R7 R8: four-zero substitution with both parities
    dq.delete(); bq.delete();
    addp(dq, bq, 1, 0, 1); addp(dq, bq, 0, 0, 4); addp(dq, bq, 1, 0, 2);
    addp(dq, bq, 0, 0, 4); addp(dq, bq, 0, 0, 8); addp(dq, bq, 0, 0, 3);
    addp(dq, bq, 1, 0, 1); addp(dq, bq, 0, 0, 5); addp(dq, bq, 1, 0, 3);
    addp(dq, bq, 0, 0, 4); addp(dq, bq, 1, 0, 1);
    do_reset(1'b1, 1'b0, 1'b1, 1'b1);
    enc_segment(1'b1, 1'b0, dq, bq, "R7 R8");

    // R8 R5: AMI at E1, long zero run left alone
    dq.delete(); bq.delete();
    addp(dq, bq, 1, 0, 3); addp(dq, bq, 0, 0, 6); addp(dq, bq, 1, 0, 1);
    addp(dq, bq, 0, 0, 1); addp(dq, bq, 1, 0, 2);
    do_reset(1'b0, 1'b0, 1'b1, 1'b1);
    enc_segment(1'b0, 1'b0, dq, bq, "R8 R5");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule